// File: doc/BRIEF.md
# Static Branch Policy Fetch Redirect Controller

This controller steers instruction fetch around conditional branches in a five-stage in-order pipeline made of fetch, decode, execute, memory and writeback. It owns the fetch address register. When decode reports a branch, it applies one of four static policies: hold fetch until the outcome is known, keep fetching sequentially, jump to the target at once, or always execute one delay-slot instruction. When the guess is wrong, it clears the valid bit of the IF/ID, ID/EX or EX/MEM pipeline register so that the wrong instructions become no-ops.

The outcome can be resolved in decode, which gives a one-cycle shadow, or in the memory stage, which gives a three-cycle shadow. A parameter fixes the resolve stage or leaves it to a run-time input. Policy, resolve stage and delay-slot annul are captured when a branch enters decode, and they hold until that branch resolves. A saturating counter adds up every lost fetch slot, so the penalty of each policy and outcome can be read directly.

Top module: `branch_fetch_ctrl`

## Requirements
- R1: While reset is high, and at the first sample after the reset edge, the fetch PC equals RESET_VEC, all squash and stall outputs are low, and the penalty count is zero.
- R2: With no branch, the fetch PC advances by STEP bytes every cycle.
- R3: Policy code 0 (freeze) has the same penalty for both outcomes. With late resolution (resolve_late_i=1, memory stage), the fetch slot of the decode cycle is squashed, fetch is stalled for the next two cycles, and the correct address (target, or fall-through) is fetched three cycles after decode. With early resolution (resolve_late_i=0), only the decode-cycle slot is squashed, and the correct address follows one cycle later.
- R4: Policy code 1 (predict not taken): a not-taken branch costs nothing and fetch stays sequential. A taken branch squashes IF/ID, ID/EX and EX/MEM together two cycles after decode when resolved late (3 slots), or squashes IF/ID in the decode cycle when resolved early (1 slot). The target is fetched in the following cycle.
- R5: Policy code 2 (predict taken): when resolved late, the decode-cycle slot is squashed and the target is fetched next cycle. A taken branch then costs 1 slot. A not-taken branch also squashes IF/ID and ID/EX two cycles after decode, for 3 slots in total, and fetches the fall-through address next. When resolved early, only a taken branch costs 1 slot.
- R6: Policy code 3 (delayed) never squashes the delay-slot instruction while annul is off. A taken branch fetches the target one cycle after decode when resolved early. When resolved late, it squashes IF/ID and ID/EX two cycles after decode (2 slots) and then fetches the target. A not-taken branch costs nothing.
- R7: Under policy 3 with annul_en_i=1, a branch whose outcome differs from br_hint_i also squashes its delay slot. This happens through IF/ID in the decode cycle when resolved early, or through EX/MEM two cycles after decode when resolved late. A matching hint adds no squash.
- R8: Changes to policy_i, resolve_late_i, annul_en_i, br_hint_i or br_target_i while a late-resolved branch is in flight have no effect on that branch.
- R9: br_dec_i raised while a branch is in flight is ignored.
- R10: The penalty count grows by the number of squash outputs high plus one if fetch is stalled, each cycle, and saturates at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| policy_i | input | 2 | Branch policy: 0 freeze, 1 not-taken, 2 taken, 3 delayed |
| resolve_late_i | input | 1 | 1: outcome known in memory stage; 0: in decode (used when RESOLVE_MODE=2) |
| annul_en_i | input | 1 | Squash delay slot on hint mismatch (policy 3) |
| br_dec_i | input | 1 | A branch is in decode this cycle |
| br_hint_i | input | 1 | Static taken hint carried with the branch |
| br_taken_i | input | 1 | Branch outcome, sampled in the resolve cycle |
| br_target_i | input | AW | Branch target address |
| fallthru_pc_i | input | AW | Address of the instruction after the branch |
| fetch_pc_o | output | AW | Address fetched this cycle |
| fetch_stall_o | output | 1 | Fetch held this cycle |
| squash_ifid_o | output | 1 | Clear valid of IF/ID at this edge |
| squash_idex_o | output | 1 | Clear valid of ID/EX at this edge |
| squash_exmem_o | output | 1 | Clear valid of EX/MEM at this edge |
| stall_cnt_o | output | CNT_W | Saturating lost-slot count |

## Verification
Squash and stall outputs are combinational on the current branch state, so they are due in the cycle that decode reports the branch (offset 0), or two cycles later for late resolution. The bench samples them one nanosecond after driving each negative edge, before the next rising edge. The redirected fetch PC and the penalty count come from registers: they are due one cycle after the resolve cycle (offset 1 early, offset 3 late), and the bench reads them at that cycle's negative edge. During offsets 1 and 2 of every late branch, the bench scrambles the configuration inputs and raises a second branch flag, then expects the original results unchanged.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

   typedef enum logic [1:0] {
      POL_FREEZE    = 2'd0,
      POL_NOT_TAKEN = 2'd1,
      POL_TAKEN     = 2'd2,
      POL_DELAYED   = 2'd3
   } bhc_policy_e;

   typedef struct packed {
      bhc_policy_e pol;
      logic        late;
      logic        annul;
      logic        hint;
   } bhc_cfg_t;

   localparam int unsigned SQ_W     = 3;
   localparam int unsigned SQ_IFID  = 0;
   localparam int unsigned SQ_IDEX  = 1;
   localparam int unsigned SQ_EXMEM = 2;
   localparam int unsigned AGE_W    = 2;

endpackage

// File: rtl/bhc_flight_track.sv
module bhc_flight_track
   import bhc_pkg::*;
#(
   parameter int unsigned AW = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             br_dec_i,
   input  bhc_cfg_t         cfg_i,
   input  logic [AW-1:0]    tgt_i,
   input  logic [AW-1:0]    ft_i,
   output logic             start_o,
   output logic [AGE_W-1:0] age_o,
   output bhc_cfg_t         cfg_o,
   output logic [AW-1:0]    tgt_o,
   output logic [AW-1:0]    ft_o
);

   logic [AGE_W-1:0] age_q;
   bhc_cfg_t         cfg_q;
   logic [AW-1:0]    tgt_q;
   logic [AW-1:0]    ft_q;
   logic             idle;

   assign idle    = (age_q == '0);
   assign start_o = br_dec_i & idle;
   assign age_o   = age_q;
   assign cfg_o   = start_o ? cfg_i : cfg_q;
   assign tgt_o   = start_o ? tgt_i : tgt_q;
   assign ft_o    = start_o ? ft_i  : ft_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         age_q <= '0;
      end else begin
         case (age_q)
            2'd0:    age_q <= (start_o && cfg_i.late) ? 2'd1 : 2'd0;
            2'd1:    age_q <= 2'd2;
            default: age_q <= 2'd0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_q <= '0;
         tgt_q <= '0;
         ft_q  <= '0;
      end else if (start_o) begin
         cfg_q <= cfg_i;
         tgt_q <= tgt_i;
         ft_q  <= ft_i;
      end
   end

   a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
      (age_q == 2'd1) |=> ($stable(cfg_q) && $stable(tgt_q) && $stable(ft_q)));

   a_r9_flight_mid: assert property (@(posedge clk) disable iff (rst)
      (age_q == 2'd1) |=> (age_q == 2'd2));

   a_r9_flight_end: assert property (@(posedge clk) disable iff (rst)
      (age_q == 2'd2) |=> (age_q == 2'd0));

endmodule

// File: rtl/bhc_redirect_logic.sv
module bhc_redirect_logic
   import bhc_pkg::*;
#(
   parameter int unsigned AW = 32
) (
   input  logic             start_i,
   input  logic [AGE_W-1:0] age_i,
   input  bhc_cfg_t         cfg_i,
   input  logic             taken_i,
   input  logic [AW-1:0]    tgt_i,
   input  logic [AW-1:0]    ft_i,
   output logic [SQ_W-1:0]  squash_o,
   output logic             stall_o,
   output logic             redir_o,
   output logic [AW-1:0]    redir_pc_o
);

   logic mispredict;
   logic [AW-1:0] resolved_pc;

   assign mispredict  = cfg_i.annul & (cfg_i.hint != taken_i);
   assign resolved_pc = taken_i ? tgt_i : ft_i;

   always_comb begin
      squash_o   = '0;
      stall_o    = 1'b0;
      redir_o    = 1'b0;
      redir_pc_o = ft_i;
      if (start_i && !cfg_i.late) begin
         case (cfg_i.pol)
            POL_FREEZE: begin
               squash_o[SQ_IFID] = 1'b1;
               redir_o           = 1'b1;
               redir_pc_o        = resolved_pc;
            end
            POL_NOT_TAKEN, POL_TAKEN: begin
               if (taken_i) begin
                  squash_o[SQ_IFID] = 1'b1;
                  redir_o           = 1'b1;
                  redir_pc_o        = tgt_i;
               end
            end
            default: begin
               if (taken_i) begin
                  redir_o    = 1'b1;
                  redir_pc_o = tgt_i;
               end
               if (mispredict) squash_o[SQ_IFID] = 1'b1;
            end
         endcase
      end else if (start_i) begin
         case (cfg_i.pol)
            POL_FREEZE: begin
               squash_o[SQ_IFID] = 1'b1;
               redir_o           = 1'b1;
               redir_pc_o        = ft_i;
            end
            POL_TAKEN: begin
               squash_o[SQ_IFID] = 1'b1;
               redir_o           = 1'b1;
               redir_pc_o        = tgt_i;
            end
            default: begin
               redir_o = 1'b0;
            end
         endcase
      end else if (age_i == 2'd1) begin
         stall_o = (cfg_i.pol == POL_FREEZE);
      end else if (age_i == 2'd2) begin
         case (cfg_i.pol)
            POL_FREEZE: begin
               stall_o    = 1'b1;
               redir_o    = 1'b1;
               redir_pc_o = resolved_pc;
            end
            POL_NOT_TAKEN: begin
               if (taken_i) begin
                  squash_o   = '1;
                  redir_o    = 1'b1;
                  redir_pc_o = tgt_i;
               end
            end
            POL_TAKEN: begin
               if (!taken_i) begin
                  squash_o[SQ_IFID] = 1'b1;
                  squash_o[SQ_IDEX] = 1'b1;
                  redir_o           = 1'b1;
                  redir_pc_o        = ft_i;
               end
            end
            default: begin
               if (taken_i) begin
                  squash_o[SQ_IFID] = 1'b1;
                  squash_o[SQ_IDEX] = 1'b1;
                  redir_o           = 1'b1;
                  redir_pc_o        = tgt_i;
               end
               if (mispredict) squash_o[SQ_EXMEM] = 1'b1;
            end
         endcase
      end
   end

endmodule

// File: rtl/bhc_pc_reg.sv
module bhc_pc_reg #(
   parameter int unsigned   AW        = 32,
   parameter int unsigned   STEP      = 4,
   parameter logic [AW-1:0] RESET_VEC = '0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          stall_i,
   input  logic          redir_i,
   input  logic [AW-1:0] redir_pc_i,
   output logic [AW-1:0] pc_o
);

   localparam logic [AW-1:0] STEP_V = AW'(STEP);

   logic [AW-1:0] pc_q;
   logic [AW-1:0] pc_d;

   always_comb begin
      if (redir_i)      pc_d = redir_pc_i;
      else if (stall_i) pc_d = pc_q;
      else              pc_d = pc_q + STEP_V;
   end

   always_ff @(posedge clk) begin
      if (rst) pc_q <= RESET_VEC;
      else     pc_q <= pc_d;
   end

   assign pc_o = pc_q;

   a_r2_step: assert property (@(posedge clk) disable iff (rst)
      (!stall_i && !redir_i) |=> (pc_q == $past(pc_q) + STEP_V));

endmodule

// File: rtl/bhc_penalty_cnt.sv
module bhc_penalty_cnt
   import bhc_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SQ_W-1:0]  squash_i,
   input  logic             stall_i,
   output logic [CNT_W-1:0] cnt_o
);

   localparam int unsigned   SUM_W = CNT_W + 2;
   localparam logic [CNT_W-1:0] MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic [2:0]       inc;
   logic [SUM_W-1:0] sum;

   always_comb begin
      inc = {2'b00, stall_i};
      for (int i = 0; i < int'(SQ_W); i++) begin
         inc = inc + {2'b00, squash_i[i]};
      end
      sum = {2'b00, cnt_q} + SUM_W'(inc);
   end

   always_ff @(posedge clk) begin
      if (rst)                        cnt_q <= '0;
      else if (sum > {2'b00, MAX})    cnt_q <= MAX;
      else                            cnt_q <= sum[CNT_W-1:0];
   end

   assign cnt_o = cnt_q;

   a_r10_monotone: assert property (@(posedge clk) disable iff (rst)
      (cnt_q != MAX) |=> (cnt_q >= $past(cnt_q)));

   a_r10_sat_hold: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == MAX) |=> (cnt_q == MAX));

endmodule

// File: rtl/branch_fetch_ctrl.sv
module branch_fetch_ctrl
   import bhc_pkg::*;
#(
   parameter int unsigned   AW           = 32,
   parameter int unsigned   STEP         = 4,
   parameter int unsigned   CNT_W        = 16,
   parameter int unsigned   RESOLVE_MODE = 2,
   parameter logic [AW-1:0] RESET_VEC    = 32'h0000_1000
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       policy_i,
   input  logic             resolve_late_i,
   input  logic             annul_en_i,
   input  logic             br_dec_i,
   input  logic             br_hint_i,
   input  logic             br_taken_i,
   input  logic [AW-1:0]    br_target_i,
   input  logic [AW-1:0]    fallthru_pc_i,
   output logic [AW-1:0]    fetch_pc_o,
   output logic             fetch_stall_o,
   output logic             squash_ifid_o,
   output logic             squash_idex_o,
   output logic             squash_exmem_o,
   output logic [CNT_W-1:0] stall_cnt_o
);

   if (AW < 8) begin : g_chk_aw
      $error("branch_fetch_ctrl: AW must be at least 8");
   end
   if (STEP == 0 || (STEP & (STEP - 1)) != 0) begin : g_chk_step
      $error("branch_fetch_ctrl: STEP must be a power of two");
   end
   if (CNT_W < 2) begin : g_chk_cnt
      $error("branch_fetch_ctrl: CNT_W must be at least 2");
   end
   if (RESOLVE_MODE > 2) begin : g_chk_mode
      $error("branch_fetch_ctrl: RESOLVE_MODE must be 0, 1 or 2");
   end

   logic late_sel;

   if (RESOLVE_MODE == 0) begin : g_res_decode
      assign late_sel = 1'b0;
   end else if (RESOLVE_MODE == 1) begin : g_res_memory
      assign late_sel = 1'b1;
   end else begin : g_res_runtime
      assign late_sel = resolve_late_i;
   end

   bhc_cfg_t         cfg_in;
   bhc_cfg_t         cfg_eff;
   logic             start;
   logic [AGE_W-1:0] age;
   logic [AW-1:0]    tgt_eff;
   logic [AW-1:0]    ft_eff;
   logic [SQ_W-1:0]  squash;
   logic             stall;
   logic             redir;
   logic [AW-1:0]    redir_pc;

   assign cfg_in = '{pol: bhc_policy_e'(policy_i), late: late_sel,
                     annul: annul_en_i, hint: br_hint_i};

   bhc_flight_track #(.AW(AW)) u_track (
      .clk      (clk),
      .rst      (rst),
      .br_dec_i (br_dec_i),
      .cfg_i    (cfg_in),
      .tgt_i    (br_target_i),
      .ft_i     (fallthru_pc_i),
      .start_o  (start),
      .age_o    (age),
      .cfg_o    (cfg_eff),
      .tgt_o    (tgt_eff),
      .ft_o     (ft_eff)
   );

   bhc_redirect_logic #(.AW(AW)) u_redirect (
      .start_i    (start),
      .age_i      (age),
      .cfg_i      (cfg_eff),
      .taken_i    (br_taken_i),
      .tgt_i      (tgt_eff),
      .ft_i       (ft_eff),
      .squash_o   (squash),
      .stall_o    (stall),
      .redir_o    (redir),
      .redir_pc_o (redir_pc)
   );

   bhc_pc_reg #(.AW(AW), .STEP(STEP), .RESET_VEC(RESET_VEC)) u_pc (
      .clk        (clk),
      .rst        (rst),
      .stall_i    (stall),
      .redir_i    (redir),
      .redir_pc_i (redir_pc),
      .pc_o       (fetch_pc_o)
   );

   bhc_penalty_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .squash_i (squash),
      .stall_i  (stall),
      .cnt_o    (stall_cnt_o)
   );

   assign fetch_stall_o  = stall;
   assign squash_ifid_o  = squash[SQ_IFID];
   assign squash_idex_o  = squash[SQ_IDEX];
   assign squash_exmem_o = squash[SQ_EXMEM];

   a_r3_stall_holds_pc: assert property (@(posedge clk) disable iff (rst)
      (fetch_stall_o && !redir) |=> (fetch_pc_o == $past(fetch_pc_o)));

   a_r7_exmem_at_resolve: assert property (@(posedge clk) disable iff (rst)
      squash_exmem_o |-> (age == 2'd2));

   a_r6_slot_kept: assert property (@(posedge clk) disable iff (rst)
      (start && cfg_eff.pol == POL_DELAYED && !cfg_eff.annul) |-> !squash_ifid_o);

   a_r3_stall_only_freeze: assert property (@(posedge clk) disable iff (rst)
      fetch_stall_o |-> (cfg_eff.pol == POL_FREEZE && age != 2'd0));

endmodule

// File: tb/test_branch_fetch_ctrl.sv
`timescale 1ns/1ps
module test_branch_fetch_ctrl;

   localparam int unsigned AW   = 32;
   localparam int unsigned STEP = 4;
   localparam logic [AW-1:0] RV = 32'h0000_1000;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [1:0]    policy_i = '0;
   logic          resolve_late_i = 1'b0;
   logic          annul_en_i = 1'b0;
   logic          br_dec_i = 1'b0;
   logic          br_hint_i = 1'b0;
   logic          br_taken_i = 1'b0;
   logic [AW-1:0] br_target_i = '0;
   logic [AW-1:0] fallthru_pc_i = '0;
   logic [AW-1:0] fetch_pc_o, pc_s;
   logic          fetch_stall_o, sq_ifid, sq_idex, sq_exmem;
   logic          st_s, s0_s, s1_s, s2_s;
   logic [15:0]   stall_cnt_o;
   logic [2:0]    cnt_sat;

   int checks = 0;
   int failures = 0;
   bit done = 0;
   longint total_pen = 0;

   always #2.5 clk = ~clk;

   branch_fetch_ctrl #(.AW(AW), .STEP(STEP), .CNT_W(16), .RESET_VEC(RV)) i_branch_fetch_ctrl (
      .clk(clk), .rst(rst), .policy_i(policy_i), .resolve_late_i(resolve_late_i),
      .annul_en_i(annul_en_i), .br_dec_i(br_dec_i), .br_hint_i(br_hint_i),
      .br_taken_i(br_taken_i), .br_target_i(br_target_i), .fallthru_pc_i(fallthru_pc_i),
      .fetch_pc_o(fetch_pc_o), .fetch_stall_o(fetch_stall_o), .squash_ifid_o(sq_ifid),
      .squash_idex_o(sq_idex), .squash_exmem_o(sq_exmem), .stall_cnt_o(stall_cnt_o));

   branch_fetch_ctrl #(.AW(AW), .STEP(STEP), .CNT_W(3), .RESET_VEC(RV)) i_branch_fetch_ctrl_sat (
      .clk(clk), .rst(rst), .policy_i(policy_i), .resolve_late_i(resolve_late_i),
      .annul_en_i(annul_en_i), .br_dec_i(br_dec_i), .br_hint_i(br_hint_i),
      .br_taken_i(br_taken_i), .br_target_i(br_target_i), .fallthru_pc_i(fallthru_pc_i),
      .fetch_pc_o(pc_s), .fetch_stall_o(st_s), .squash_ifid_o(s0_s),
      .squash_idex_o(s1_s), .squash_exmem_o(s2_s), .stall_cnt_o(cnt_sat));

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic string pol_tag(input int pol, input int an);
      case (pol)
         0: return "R3";
         1: return "R4";
         2: return "R5";
         default: return (an != 0) ? "R6 R7" : "R6";
      endcase
   endfunction

   // {stall, exmem, idex, ifid} expected at offset off after decode
   function automatic logic [3:0] exp_vec(input int pol, input int late, input int tk,
                                          input int an, input int hint, input int off);
      bit mis;
      mis = (pol == 3) && (an != 0) && (hint != tk);
      if (late == 0) begin
         if (off != 0) return 4'b0000;
         case (pol)
            0: return 4'b0001;
            1, 2: return tk ? 4'b0001 : 4'b0000;
            default: return mis ? 4'b0001 : 4'b0000;
         endcase
      end
      case (off)
         0: return (pol == 0 || pol == 2) ? 4'b0001 : 4'b0000;
         1: return (pol == 0) ? 4'b1000 : 4'b0000;
         default: begin
            case (pol)
               0: return 4'b1000;
               1: return tk ? 4'b0111 : 4'b0000;
               2: return tk ? 4'b0000 : 4'b0011;
               default: return (tk ? 4'b0011 : 4'b0000) | (mis ? 4'b0100 : 4'b0000);
            endcase
         end
      endcase
   endfunction

   function automatic int exp_pen(input int pol, input int late, input int tk,
                                  input int an, input int hint);
      int mis;
      mis = ((pol == 3) && (an != 0) && (hint != tk)) ? 1 : 0;
      if (late == 0) begin
         case (pol)
            0: return 1;
            1, 2: return tk;
            default: return mis;
         endcase
      end
      case (pol)
         0: return 3;
         1: return tk ? 3 : 0;
         2: return tk ? 1 : 3;
         default: return (tk ? 2 : 0) + mis;
      endcase
   endfunction

   function automatic logic [AW-1:0] exp_pc(input int pol, input int late, input int tk,
                                            input logic [AW-1:0] pc0, input logic [AW-1:0] tgt);
      if (late == 0) begin
         if (pol == 0) return tk ? tgt : pc0;
         return tk ? tgt : pc0 + STEP;
      end
      case (pol)
         0: return tk ? tgt : pc0;
         2: return tk ? tgt + 2 * STEP : pc0;
         default: return tk ? tgt : pc0 + 3 * STEP;
      endcase
   endfunction

   task automatic run_branch(input int pol, input int late, input int tk,
                             input int an, input int hint, input int idx);
      logic [AW-1:0] pc0, tgt;
      longint c0;
      logic [3:0] v;
      string tag;
      tag = pol_tag(pol, an);
      @(negedge clk);
      pc0 = fetch_pc_o;
      c0  = stall_cnt_o;
      tgt = 32'h0004_0000 + 32'(idx) * 64;
      policy_i = 2'(pol); resolve_late_i = 1'(late); annul_en_i = 1'(an);
      br_hint_i = 1'(hint); br_taken_i = 1'(tk); br_target_i = tgt;
      fallthru_pc_i = pc0; br_dec_i = 1'b1;
      #1;
      v = {fetch_stall_o, sq_exmem, sq_idex, sq_ifid};
      chk(v == exp_vec(pol, late, tk, an, hint, 0), {tag, " decode-cycle squash"},
          longint'(v), longint'(exp_vec(pol, late, tk, an, hint, 0)));
      if (late != 0) begin
         for (int off = 1; off <= 2; off++) begin
            @(negedge clk);
            br_dec_i = 1'b1;                       // R9: ignored while in flight
            policy_i = 2'(pol + 1);                // R8: changes ignored
            resolve_late_i = 1'b0;
            annul_en_i = ~annul_en_i;
            br_hint_i = ~br_hint_i;
            br_target_i = tgt ^ 32'h0000_0100;
            #1;
            v = {fetch_stall_o, sq_exmem, sq_idex, sq_ifid};
            chk(v == exp_vec(pol, late, tk, an, hint, off), {tag, " R8 R9 shadow squash"},
                longint'(v), longint'(exp_vec(pol, late, tk, an, hint, off)));
         end
      end
      @(negedge clk);
      br_dec_i = 1'b0;
      #1;
      chk(fetch_pc_o == exp_pc(pol, late, tk, pc0, tgt), {tag, " redirect pc"},
          longint'(fetch_pc_o), longint'(exp_pc(pol, late, tk, pc0, tgt)));
      chk(longint'(stall_cnt_o) - c0 == longint'(exp_pen(pol, late, tk, an, hint)),
          {tag, " R10 penalty"}, longint'(stall_cnt_o) - c0,
          longint'(exp_pen(pol, late, tk, an, hint)));
      total_pen += exp_pen(pol, late, tk, an, hint);
   endtask

   initial begin
      logic [AW-1:0] p;
      int idx;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(fetch_pc_o == RV, "R1 reset pc", longint'(fetch_pc_o), longint'(RV));
      chk({fetch_stall_o, sq_exmem, sq_idex, sq_ifid} == 4'b0, "R1 reset squash", 0, 0);
      chk(stall_cnt_o == 0, "R1 reset count", longint'(stall_cnt_o), 0);
      rst = 1'b0;
      @(negedge clk);
      chk(fetch_pc_o == RV + STEP, "R1 first step", longint'(fetch_pc_o), longint'(RV + STEP));
      for (int i = 0; i < 4; i++) begin
         p = fetch_pc_o;
         @(negedge clk);
         chk(fetch_pc_o == p + STEP, "R2 sequential", longint'(fetch_pc_o), longint'(p + STEP));
      end
      idx = 0;
      for (int pol = 0; pol < 4; pol++)
         for (int late = 0; late < 2; late++)
            for (int tk = 0; tk < 2; tk++)
               for (int an = 0; an < 2; an++)
                  for (int hint = 0; hint < 2; hint++) begin
                     run_branch(pol, late, tk, an, hint, idx);
                     idx++;
                  end
      @(negedge clk);
      chk(longint'(stall_cnt_o) == total_pen, "R10 total count",
          longint'(stall_cnt_o), total_pen);
      chk(cnt_sat == 3'd7, "R10 saturation", longint'(cnt_sat), 7);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog all requirements actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule